// File: doc/BRIEF.md
# Gated encoded clock divider

The block derives a slower clock from its parent clock, together with a one-cycle clock-enable strobe, and gates both under host control. A small register port holds three words: an encoded divisor field, a gate enable bit and a status word. The divisor field uses non-linear codes. A field of zero selects the largest plain ratio. In the optional wide mode, the top field bit switches to a fixed divide-by-64 prescale of the lower five bits.

Divisor updates go through a handshake that software polls. After a divisor write, the update machine moves from `UPD_IDLE` to `UPD_WAIT` and raises a wait flag until the running output period ends (transition "boundary reached"). The new ratio loads at that boundary. The machine then sits in `UPD_SETTLE` with a settle flag for a fixed number of cycles (transition "settle done") and returns to `UPD_IDLE`. The divisor register ignores writes outside `UPD_IDLE`.

The output gate machine has three states. `GATE_OFF` moves to `GATE_RUN` on "enable at boundary". `GATE_RUN` moves to `GATE_DRAIN` on "disable while high", or straight to `GATE_OFF` on "disable while low". `GATE_DRAIN` moves to `GATE_OFF` on "high phase over" and back to `GATE_RUN` on "re-enable".

Top module: `clkdiv_gated`

## Requirements
- R1: After reset, the divided output and the strobe are low. The divisor register (address 0), the gate register (address 1), the status word (address 2) and address 3 all read zero.
- R2: A non-zero divisor field below the wide-mode flag gives a ratio equal to the field. The strobe pulses for one cycle once per ratio cycles, and the divisor register reads back the stored field.
- R3: A divisor field of zero gives a ratio of 2 to the power of the field width: 32 for the 5-bit field and 64 for the 6-bit field. This is also the ratio after reset.
- R4: In wide mode (6-bit field), a field with bit 5 set gives a ratio of 64 times bits 4..0, and a value of zero in bits 4..0 gives 64. In narrow mode, only bits 4..0 of the written word are stored.
- R5: For a ratio r of 2 or more, each period has a high phase of floor(r/2) cycles followed by a low phase of ceil(r/2) cycles. For a ratio of 1, the output stays low and the strobe is high every cycle.
- R6: Status bit 3 is set from a divisor write until the current period ends. Status bit 4 is then set for exactly SETTLE_CYCLES cycles. The two bits are never set together, all other status bits read zero, and the word reads zero when the update is done.
- R7: A divisor write made while status is non-zero is ignored: the read-back field and the ratio that follows keep the first value.
- R8: A new ratio takes effect only at the end of the period that is running. The output rises only at the start of a period.
- R9: Bit 0 of the gate register reads back as written. Setting it starts the output at the next period start, and the first high phase is full length.
- R10: Clearing the gate bit during a high phase lets that phase finish at full length. After that, the output stays low and the strobe stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 divisor, 1 gate, 2 status |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register (combinational) |
| div_clk_o | output | 1 | Gated divided clock, registered |
| div_tick_o | output | 1 | One-cycle strobe at each gated period start |

## Verification
Loading the pending ratio and starting the next output period happen in the same parent cycle. That cycle also produces the strobe and the rising edge of the output. The bench provokes this by writing a smaller divisor right after a strobe. The strobe spacing must then read the full old ratio once and the new ratio next, and the assertions check that the output rises and the ratio changes only with the counter at zero. A second overlap puts a rejected divisor write inside the wait phase of an accepted one. The bench judges that case by the read-back field and by the ratio measured afterwards.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // register addresses
    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_GATE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // status bit positions (software polls bits 4:3)
    localparam int STAT_WAIT_BIT   = 3;
    localparam int STAT_SETTLE_BIT = 4;

    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_WAIT   = 2'd1,
        UPD_SETTLE = 2'd2
    } upd_state_t;

    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_RUN   = 2'd1,
        GATE_DRAIN = 2'd2
    } gate_state_t;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
    parameter int WIDE_FIELD = 0,
    parameter int FIELD_W    = 5,
    parameter int RATIO_W    = 6
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int FULL_RATIO = 1 << FIELD_W;

    generate
        if (WIDE_FIELD != 0) begin : g_wide
            localparam int LOW_W = FIELD_W - 1;
            localparam int PRE_W = 6;
            logic [LOW_W-1:0] low;
            assign low = field_i[LOW_W-1:0];
            always_comb begin
                if (field_i[FIELD_W-1]) begin
                    // prescaled code: 64 x lower bits, zero lower bits = 64
                    if (low == '0) ratio_o = RATIO_W'(FULL_RATIO);
                    else           ratio_o = RATIO_W'({low, {PRE_W{1'b0}}});
                end else if (field_i == '0) begin
                    ratio_o = RATIO_W'(FULL_RATIO);
                end else begin
                    ratio_o = RATIO_W'(field_i);
                end
            end
        end else begin : g_narrow
            always_comb begin
                if (field_i == '0) ratio_o = RATIO_W'(FULL_RATIO);
                else               ratio_o = RATIO_W'(field_i);
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int FIELD_W       = 5,
    parameter int REG_W         = 8,
    parameter int SETTLE_CYCLES = 4,
    parameter int SETTLE_W      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               period_end,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [FIELD_W-1:0] field_q,
    output logic               gate_en_q,
    output logic               upd_req
);
    upd_state_t          upd_q, upd_n;
    logic [SETTLE_W-1:0] settle_q;
    logic                div_wr;
    logic                settle_done;

    assign div_wr      = reg_wr && (reg_addr == ADDR_DIV);
    assign settle_done = (settle_q == SETTLE_W'(SETTLE_CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= UPD_IDLE;
        else        upd_q <= upd_n;
    end

    // next state
    always_comb begin
        upd_n = upd_q;
        unique case (upd_q)
            UPD_IDLE:   if (div_wr)      upd_n = UPD_WAIT;
            UPD_WAIT:   if (period_end)  upd_n = UPD_SETTLE;
            UPD_SETTLE: if (settle_done) upd_n = UPD_IDLE;
            default:                     upd_n = UPD_IDLE;
        endcase
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q   <= '0;
            gate_en_q <= 1'b0;
            settle_q  <= '0;
        end else begin
            if (upd_q == UPD_IDLE && div_wr)
                field_q <= reg_wdata[FIELD_W-1:0];
            if (reg_wr && reg_addr == ADDR_GATE)
                gate_en_q <= reg_wdata[0];
            if (upd_q == UPD_SETTLE) settle_q <= settle_q + 1'b1;
            else                     settle_q <= '0;
        end
    end

    // outputs
    always_comb begin
        upd_req   = (upd_q == UPD_WAIT);
        reg_rdata = '0;
        case (reg_addr)
            ADDR_DIV:  reg_rdata[FIELD_W-1:0] = field_q;
            ADDR_GATE: reg_rdata[0]           = gate_en_q;
            ADDR_STAT: begin
                reg_rdata[STAT_WAIT_BIT]   = (upd_q == UPD_WAIT);
                reg_rdata[STAT_SETTLE_BIT] = (upd_q == UPD_SETTLE);
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q != UPD_IDLE && div_wr) |=> $stable(field_q));

    assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STAT) |-> $onehot0(reg_rdata));

    assert_settle_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q == UPD_SETTLE) |-> (settle_q < SETTLE_W'(SETTLE_CYCLES)));

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W     = 6,
    parameter int RESET_RATIO = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_en,
    input  logic               upd_req,
    input  logic [RATIO_W-1:0] new_ratio,
    output logic               period_end,
    output logic               div_clk_o,
    output logic               div_tick_o
);
    gate_state_t        gst_q, gst_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] ratio_q, ratio_n;
    logic               high_n;
    logic               div_q, div_n;
    logic               tick_q, tick_n;

    // counter and ratio
    always_comb begin
        period_end = (cnt_q == ratio_q - RATIO_W'(1));
        ratio_n    = (upd_req && period_end) ? new_ratio : ratio_q;
        cnt_n      = period_end ? '0 : cnt_q + 1'b1;
        high_n     = (cnt_n < (ratio_n >> 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gst_q <= GATE_OFF;
        else        gst_q <= gst_n;
    end

    // next state
    always_comb begin
        gst_n = gst_q;
        unique case (gst_q)
            GATE_OFF: if (gate_en && period_end) gst_n = GATE_RUN;
            GATE_RUN: if (!gate_en) gst_n = (div_q && high_n) ? GATE_DRAIN : GATE_OFF;
            GATE_DRAIN: begin
                if (gate_en)      gst_n = GATE_RUN;
                else if (!high_n) gst_n = GATE_OFF;
            end
            default: gst_n = GATE_OFF;
        endcase
    end

    // outputs
    always_comb begin
        div_n  = (gst_n != GATE_OFF) && high_n;
        tick_n = (gst_n == GATE_RUN) && period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RATIO_W'(RESET_RATIO);
            div_q   <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            ratio_q <= ratio_n;
            div_q   <= div_n;
            tick_q  <= tick_n;
        end
    end

    assign div_clk_o  = div_q;
    assign div_tick_o = tick_q;

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q);

    assert_tick_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> (cnt_q == '0));

    assert_rise_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> (cnt_q == '0));

    assert_ratio_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_q) |-> (cnt_q == '0));

    assert_off_is_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gst_q == GATE_OFF) |-> (!div_q && !tick_q));

endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated
    import clkdiv_pkg::*;
#(
    parameter int WIDE_FIELD    = 0,
    parameter int REG_W         = 8,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             div_clk_o,
    output logic             div_tick_o
);
    localparam int FIELD_W     = (WIDE_FIELD != 0) ? 6 : 5;
    localparam int RATIO_W     = (WIDE_FIELD != 0) ? 11 : 6;
    localparam int RESET_RATIO = 1 << FIELD_W;
    localparam int SETTLE_W    = $clog2(SETTLE_CYCLES + 1);

    logic [FIELD_W-1:0] field;
    logic [RATIO_W-1:0] ratio;
    logic               gate_en;
    logic               upd_req;
    logic               period_end;

    clkdiv_regs #(
        .FIELD_W(FIELD_W), .REG_W(REG_W),
        .SETTLE_CYCLES(SETTLE_CYCLES), .SETTLE_W(SETTLE_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .period_end(period_end), .reg_rdata(reg_rdata),
        .field_q(field), .gate_en_q(gate_en), .upd_req(upd_req)
    );

    clkdiv_decode #(
        .WIDE_FIELD(WIDE_FIELD), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W)
    ) decode_i (
        .field_i(field), .ratio_o(ratio)
    );

    clkdiv_core #(
        .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
    ) core_i (
        .clk(clk), .rst_n(rst_n),
        .gate_en(gate_en), .upd_req(upd_req), .new_ratio(ratio),
        .period_end(period_end),
        .div_clk_o(div_clk_o), .div_tick_o(div_tick_o)
    );

endmodule

// File: tb/clkdiv_gated_tb_top.sv
module clkdiv_gated_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] rdata_w, rdata_n;
    logic       out_w, out_n, tick_w, tick_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    clkdiv_gated #(.WIDE_FIELD(1), .REG_W(8), .SETTLE_CYCLES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_w),
        .div_clk_o(out_w), .div_tick_o(tick_w));

    clkdiv_gated #(.WIDE_FIELD(0), .REG_W(8), .SETTLE_CYCLES(4)) dut_n (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
        .div_clk_o(out_n), .div_tick_o(tick_n));

    // field, expected wide ratio, expected narrow ratio
    localparam int NV = 11;
    localparam int V_FIELD[NV]  = '{'h04, 'h05, 'h01, 'h00, 'h02, 'h21, 'h22, 'h20, 'h3F, 'h07, 'h25};
    localparam int V_WIDE[NV]   = '{4, 5, 1, 64, 2, 64, 128, 64, 1984, 7, 320};
    localparam int V_NARROW[NV] = '{4, 5, 1, 32, 2, 1, 2, 32, 31, 7, 5};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic get_tick(input int sel);
        return (sel == 0) ? tick_w : tick_n;
    endfunction

    function automatic logic get_out(input int sel);
        return (sel == 0) ? out_w : out_n;
    endfunction

    task automatic rd(input logic [1:0] a, output int w, output int n);
        reg_addr = a;
        #1;
        w = int'(rdata_w);
        n = int'(rdata_n);
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        reg_addr  = a;
        reg_wdata = 8'(d);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        int w, n;
        forever begin
            rd(2'd2, w, n);
            if (w == 0 && n == 0) return;
            @(negedge clk);
        end
    endtask

    task automatic measure_period(input int sel, output int p);
        @(negedge clk);
        while (!get_tick(sel)) @(negedge clk);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!get_tick(sel));
    endtask

    task automatic measure_duty(input int sel, output int h, output int l);
        @(negedge clk);
        while (get_out(sel)) @(negedge clk);
        while (!get_out(sel)) @(negedge clk);
        h = 0;
        while (get_out(sel)) begin h++; @(negedge clk); end
        l = 0;
        while (!get_out(sel)) begin l++; @(negedge clk); end
    endtask

    initial begin
        int w, n, p, h, l, cnt, hi_seen, tk_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), w, n);
            chk($sformatf("R1 reset read addr %0d wide", a), w, 0);
            chk($sformatf("R1 reset read addr %0d narrow", a), n, 0);
        end
        hi_seen = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (out_w || out_n || tick_w || tick_n) hi_seen++;
        end
        chk("R1 outputs quiet while gate off", hi_seen, 0);

        // R9 enable, R3 reset ratio
        @(negedge clk);
        wr(2'd1, 1);
        rd(2'd1, w, n);
        chk("R9 gate readback wide", w, 1);
        chk("R9 gate readback narrow", n, 1);
        measure_duty(0, h, l);
        chk("R9 first high phase full wide", h, 32);
        measure_period(0, p);
        chk("R3 reset ratio wide", p, 64);
        measure_period(1, p);
        chk("R3 reset ratio narrow", p, 32);

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < NV; v++) begin
            wait_idle();
            @(negedge clk);
            wr(2'd0, V_FIELD[v]);
            wait_idle();
            rd(2'd0, w, n);
            chk($sformatf("R2 R4 readback wide field %0h", V_FIELD[v]), w, V_FIELD[v]);
            chk($sformatf("R4 readback narrow field %0h", V_FIELD[v]), n, V_FIELD[v] & 'h1F);
            measure_period(0, p);
            chk($sformatf("R2 R3 R4 period wide field %0h", V_FIELD[v]), p, V_WIDE[v]);
            measure_period(1, p);
            chk($sformatf("R2 R3 R4 period narrow field %0h", V_FIELD[v]), p, V_NARROW[v]);
            for (int s = 0; s < 2; s++) begin
                int r;
                r = (s == 0) ? V_WIDE[v] : V_NARROW[v];
                if (r == 1) begin
                    hi_seen = 0;
                    tk_seen = 0;
                    for (int i = 0; i < 10; i++) begin
                        @(negedge clk);
                        if (get_out(s)) hi_seen++;
                        if (get_tick(s)) tk_seen++;
                    end
                    chk($sformatf("R5 ratio one output low dut %0d", s), hi_seen, 0);
                    chk($sformatf("R5 ratio one strobe every cycle dut %0d", s), tk_seen, 10);
                end else begin
                    measure_duty(s, h, l);
                    chk($sformatf("R5 high phase ratio %0d", r), h, r / 2);
                    chk($sformatf("R5 low phase ratio %0d", r), l, r - r / 2);
                end
            end
        end

        // R8: change at period boundary
        wait_idle();
        @(negedge clk);
        wr(2'd0, 'h08);
        wait_idle();
        @(negedge clk);
        while (!tick_w) @(negedge clk);
        wr(2'd0, 'h04);
        cnt = 1;
        while (!tick_w) begin @(negedge clk); cnt++; end
        chk("R8 old period completes", cnt, 8);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!tick_w);
        chk("R8 new ratio next period", cnt, 4);

        // R7: write during busy ignored
        wait_idle();
        @(negedge clk);
        wr(2'd0, 'h06);
        wr(2'd0, 'h0A);
        wait_idle();
        rd(2'd0, w, n);
        chk("R7 busy write ignored readback wide", w, 6);
        chk("R7 busy write ignored readback narrow", n, 6);
        measure_period(0, p);
        chk("R7 ratio keeps first write", p, 6);

        // R6: status sequence
        wait_idle();
        @(negedge clk);
        wr(2'd0, 'h0C);
        rd(2'd2, w, n);
        chk("R6 wait flag after write", w, 'h08);
        while (w == 'h08) begin @(negedge clk); rd(2'd2, w, n); end
        chk("R6 settle flag follows wait", w, 'h10);
        cnt = 0;
        while (w == 'h10) begin cnt++; @(negedge clk); rd(2'd2, w, n); end
        chk("R6 settle length", cnt, 4);
        chk("R6 status clear when done", w, 0);

        // R10: disable during high phase
        wait_idle();
        @(negedge clk);
        wr(2'd0, 'h08);
        wait_idle();
        @(negedge clk);
        while (out_w) @(negedge clk);
        while (!out_w) @(negedge clk);
        wr(2'd1, 0);
        h = 1;
        while (out_w) begin h++; @(negedge clk); end
        chk("R10 high phase finishes", h, 4);
        hi_seen = 0;
        tk_seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_w) hi_seen++;
            if (tick_w) tk_seen++;
        end
        chk("R10 output held low", hi_seen, 0);
        chk("R10 strobe quiet", tk_seen, 0);
        rd(2'd1, w, n);
        chk("R9 gate reads back cleared", w, 0);

        // R9: re-enable gives full first high phase
        @(negedge clk);
        wr(2'd1, 1);
        measure_duty(0, h, l);
        chk("R9 re-enable full high phase", h, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule